// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block sits beside a processor core and decides whether the core should be interrupted. It collects interrupt events from two kinds of source. The first kind is a set of external request pins, each with edge detection and a per-pin polarity select. The second kind is internal event lines. Events are gathered between instruction-cycle boundaries. When the core marks the start of an instruction cycle, the gathered events are folded into a set of sticky pending flags. Each pending flag stays set until it is explicitly cleared.

For the rest of the cycle, the controller looks at every source that is both pending and enabled and picks the one with the highest priority. It then compares that priority with the priority the core is currently running at. The controller raises a request only when the candidate is strictly higher. With the request it presents the winning source number, the level the core should adopt, and the handler address. The handler address is taken from either the default or the alternate vector table. If the core is sleeping or idling, the same qualified request also raises a wake-up signal.

The core itself feeds its running level back on `cpu_ipl`. After accepting a request it adopts `irq_ipl`, and from then on anything at that level or below is held off until the level is lowered again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: New events reach the pending flags only at a clock edge where `cyc_start` is 1. An event that arrives between two cycle starts stays invisible on `irq_req` until the next cycle start has been taken.
- R2: A pending source with its `src_en` bit at 0 never produces a request.
- R3: `irq_req` is 1 only if the best candidate priority is strictly greater than `cpu_ipl`. Priority 0 never requests.
- R4: Among pending, enabled sources, the highest 3-bit priority wins. On a tie, the lowest source index wins.
- R5: While `irq_req` is 1, `irq_ipl` equals the winner's priority and `irq_src` equals the winner's index.
- R6: `irq_vec` equals the table base plus twice `irq_src`. The base is `DEF_BASE` (4) when `alt_tbl` is 0. When `alt_tbl` is 1, the base is `DEF_BASE + 2*NUM_SRC` (20 with defaults).
- R7: External pins occupy source indices 0 to 4, and internal events occupy indices 5 and up. For an external pin, `ext_pol` 0 detects a rising edge and 1 detects a falling edge. The opposite edge is ignored.
- R8: `wake` is 1 in exactly those cycles where `irq_req` is 1 and either `core_sleep` or `core_idle` is 1.
- R9: A pending flag stays set across later cycle starts until a clock edge with its `flag_clr` bit at 1 clears it.
- R10: After reset, no flag is pending and `irq_req` is 0.
- R11: While `irq_req` is 0, `irq_src`, `irq_ipl` and `irq_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Instruction-cycle start strobe; latches events into pending |
| ext_pin | input | NUM_EXT | External request pins |
| ext_pol | input | NUM_EXT | Edge polarity per pin: 0 rising, 1 falling |
| int_evt | input | NUM_INT | Internal event lines |
| flag_clr | input | NUM_SRC | Per-source pending clear strobe |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*PRIO_W | Packed priority per source, source i at bits [i*PRIO_W +: PRIO_W] |
| cpu_ipl | input | PRIO_W | Core's current running priority |
| alt_tbl | input | 1 | Select alternate vector table |
| core_sleep | input | 1 | Core is in sleep |
| core_idle | input | 1 | Core is in idle |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | IDX_W | Winning source index |
| irq_ipl | output | PRIO_W | Level the core adopts on acceptance |
| irq_vec | output | VEC_W | Handler address |
| wake | output | 1 | Wake-up for sleep and idle |

## Verification
Arbitration and table selection both act on the same request in the same cycle. So do the request and the wake-up: one qualified source both raises `irq_req` and, if the core is asleep or idle, `wake`. The bench first makes every source pending. It then sweeps each source, every priority and every running level, with both vector tables. In each cycle it judges the request, index, level and address together against values computed from the rules. It then holds a request while walking all four sleep and idle combinations, and checks that `wake` follows exactly when a request is present.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] pol,
  output logic [N-1:0] edge_o
);
  import irq_pkg::*;

  logic [N-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin;
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic rise, fall;
    assign rise = pin[g] & ~pin_q[g];
    assign fall = ~pin[g] & pin_q[g];
    assign edge_o[g] = (edge_pol_e'(pol[g]) == EDGE_FALL) ? fall : rise;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_start,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] raw_q, raw_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] capt;

  always_comb begin
    capt   = raw_q | evt;
    raw_d  = cyc_start ? '0 : capt;
    pend_d = (pend_q & ~clr) | (cyc_start ? capt : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= raw_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R1
  no_midcycle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_start) |-> ((pend_q & ~$past(pend_q)) == '0));

  // R9
  hold_until_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~$past(clr) & ~pend_q) == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N      = 8,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]   cur_lvl,
  output logic                req,
  output logic [IDX_W-1:0]    idx,
  output logic [PRIO_W-1:0]   lvl
);
  logic [PRIO_W-1:0] best_lvl;
  logic [IDX_W-1:0]  best_idx;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (prio[i*PRIO_W +: PRIO_W] > best_lvl)) begin
        best_lvl = prio[i*PRIO_W +: PRIO_W];
        best_idx = IDX_W'(i);
      end
    end
    req = (best_lvl > cur_lvl);
    idx = req ? best_idx : '0;
    lvl = req ? best_lvl : '0;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_EXT  = 5,
  parameter int NUM_INT  = 3,
  parameter int PRIO_W   = 3,
  parameter int VEC_W    = 16,
  parameter int DEF_BASE = 4,
  localparam int NUM_SRC  = NUM_EXT + NUM_INT,
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ALT_BASE = DEF_BASE + 2 * NUM_SRC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cyc_start,
  input  logic [NUM_EXT-1:0]        ext_pin,
  input  logic [NUM_EXT-1:0]        ext_pol,
  input  logic [NUM_INT-1:0]        int_evt,
  input  logic [NUM_SRC-1:0]        flag_clr,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]         cpu_ipl,
  input  logic                      alt_tbl,
  input  logic                      core_sleep,
  input  logic                      core_idle,
  output logic                      irq_req,
  output logic [IDX_W-1:0]          irq_src,
  output logic [PRIO_W-1:0]         irq_ipl,
  output logic [VEC_W-1:0]          irq_vec,
  output logic                      wake
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic [NUM_EXT-1:0] ext_edge;
  logic [NUM_SRC-1:0] evt_all;
  logic [NUM_SRC-1:0] pend;
  logic [VEC_W-1:0]   base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  irq_edge_det #(.N(NUM_EXT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pin    (ext_pin),
    .pol    (ext_pol),
    .edge_o (ext_edge)
  );

  assign evt_all = {int_evt, ext_edge};

  irq_flag_reg #(.N(NUM_SRC)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cyc_start (cyc_start),
    .evt       (evt_all),
    .clr       (flag_clr),
    .pend      (pend)
  );

  irq_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .cand    (pend & src_en),
    .prio    (src_prio),
    .cur_lvl (cpu_ipl),
    .req     (irq_req),
    .idx     (irq_src),
    .lvl     (irq_ipl)
  );

  assign base    = alt_tbl ? VEC_W'(ALT_BASE) : VEC_W'(DEF_BASE);
  assign irq_vec = irq_req ? (base + (VEC_W'(irq_src) << 1)) : '0;
  assign wake    = irq_req & (core_sleep | core_idle);

  // R3
  above_running_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (irq_ipl > cpu_ipl));

  // R2
  winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (src_en[irq_src] && pend[irq_src]));

  // R11
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !irq_req |-> (irq_src == '0 && irq_ipl == '0 && irq_vec == '0));

  // R8
  wake_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake |-> irq_req);

  // R6
  vec_in_tables_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (irq_vec >= VEC_W'(DEF_BASE) && irq_vec < VEC_W'(DEF_BASE + 4 * NUM_SRC)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  localparam int NE = 5;
  localparam int NI = 3;
  localparam int NS = NE + NI;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cyc_start;
  logic [NE-1:0] ext_pin, ext_pol;
  logic [NI-1:0] int_evt;
  logic [NS-1:0] flag_clr, src_en;
  logic [NS*PW-1:0] src_prio;
  logic [PW-1:0] cpu_ipl;
  logic          alt_tbl, core_sleep, core_idle;
  logic          irq_req, wake;
  logic [2:0]    irq_src;
  logic [PW-1:0] irq_ipl;
  logic [15:0]   irq_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ext_pin(ext_pin),
    .ext_pol(ext_pol), .int_evt(int_evt), .flag_clr(flag_clr), .src_en(src_en),
    .src_prio(src_prio), .cpu_ipl(cpu_ipl), .alt_tbl(alt_tbl),
    .core_sleep(core_sleep), .core_idle(core_idle), .irq_req(irq_req),
    .irq_src(irq_src), .irq_ipl(irq_ipl), .irq_vec(irq_vec), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_out();
    return {4'd0, irq_req, irq_src, irq_ipl, irq_vec, wake, 4'd0};
  endfunction

  function automatic logic [31:0] exp_out(input bit r, input int s, input int l,
                                          input bit alt, input bit w);
    logic [15:0] v;
    v = r ? 16'((alt ? 20 : 4) + 2 * s) : 16'd0;
    return {4'd0, r, (r ? 3'(s) : 3'd0), (r ? 3'(l) : 3'd0), v, w, 4'd0};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_cyc();
    cyc_start = 1'b1; tick(); cyc_start = 1'b0; #1;
  endtask

  task automatic clear_all();
    flag_clr = '1; tick(); flag_clr = '0; #1;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 0; cyc_start = 0; ext_pin = '0; ext_pol = '0; int_evt = '0;
    flag_clr = '0; src_en = '1; src_prio = '1; cpu_ipl = '0;
    alt_tbl = 0; core_sleep = 0; core_idle = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (5) tick();
    #1;
    // R10: nothing pending after reset even with all enabled at top priority
    chk("R10 reset", pack_out(), exp_out(0, 0, 0, 0, 0));
    pulse_cyc();
    chk("R10 empty sample", pack_out(), exp_out(0, 0, 0, 0, 0));

    // Make every source pending: rising edges on pins, pulses on internal events
    tick(); ext_pin = '1; int_evt = '1;
    tick(); int_evt = '0;
    pulse_cyc();

    // R2 R3 R5 R6: single enabled source, every priority and running level, both tables
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 8; p++)
        for (int q = 0; q < 8; q++) begin
          tick();
          src_en = NS'(1) << s;
          src_prio = {NS{3'(p)}};
          cpu_ipl = 3'(q);
          alt_tbl = (s + p + q) % 2;
          #1;
          chk("R3 R5 R6 single", pack_out(), exp_out(p > q, s, p, alt_tbl, 0));
        end

    // R2: all disabled yields no request
    tick(); src_en = '0; src_prio = '1; cpu_ipl = '0; #1;
    chk("R2 all disabled", pack_out(), exp_out(0, 0, 0, 0, 0));

    // R4: mixed enables and priorities, winner computed here
    seed = 32'h1234_5678;
    for (int it = 0; it < 300; it++) begin
      int bl, bs;
      tick();
      seed = seed * 32'd1103515245 + 32'd12345; src_en = seed[23:16];
      seed = seed * 32'd1103515245 + 32'd12345; src_prio = {seed[27:16], seed[11:0]};
      seed = seed * 32'd1103515245 + 32'd12345; cpu_ipl = seed[18:16] & 3'(it % 4);
      alt_tbl = seed[20];
      #1;
      bl = 0; bs = 0;
      for (int i = 0; i < NS; i++)
        if (src_en[i] && int'(src_prio[i*PW +: PW]) > bl) begin
          bl = int'(src_prio[i*PW +: PW]); bs = i;
        end
      chk("R4 arbitration", pack_out(), exp_out(bl > int'(cpu_ipl), bs, bl, alt_tbl, 0));
    end

    // R4 tie: equal priorities on 2,5,7 -> index 2 wins
    tick(); src_en = 8'b1010_0100; src_prio = {NS{3'd4}}; cpu_ipl = 0; alt_tbl = 0; #1;
    chk("R4 tie lowest index", pack_out(), exp_out(1, 2, 4, 0, 0));

    // R8: wake follows request and sleep/idle
    for (int r = 0; r < 2; r++)
      for (int m = 0; m < 4; m++) begin
        tick();
        src_en = 8'h01; src_prio = {NS{3'd5}}; cpu_ipl = r ? 3'd0 : 3'd7;
        core_sleep = m[0]; core_idle = m[1];
        #1;
        chk("R8 wake", pack_out(), exp_out(r == 1, 0, 5, 0, (r == 1) && (m != 0)));
      end
    tick(); core_sleep = 0; core_idle = 0;

    // R1 and R9 on internal source 5
    clear_all();
    src_en = 8'h20; src_prio = {NS{3'd3}}; cpu_ipl = 0;
    #1;
    chk("R9 cleared", pack_out(), exp_out(0, 0, 0, 0, 0));
    tick(); int_evt = 3'b001; tick(); int_evt = '0;
    tick(); #1;
    chk("R1 not before cycle start", pack_out(), exp_out(0, 0, 0, 0, 0));
    pulse_cyc();
    chk("R1 after cycle start", pack_out(), exp_out(1, 5, 3, 0, 0));
    pulse_cyc(); pulse_cyc();
    chk("R9 sticky", pack_out(), exp_out(1, 5, 3, 0, 0));
    tick(); flag_clr = 8'h20; tick(); flag_clr = '0; #1;
    chk("R9 clear strobe", pack_out(), exp_out(0, 0, 0, 0, 0));

    // R7: edge polarity per external pin (pins start high)
    for (int k = 0; k < NE; k++) begin
      tick(); src_en = NS'(1) << k; ext_pol = '0; clear_all();
      tick(); ext_pin[k] = 0; tick(); pulse_cyc();
      chk("R7 fall ignored when rising", pack_out(), exp_out(0, 0, 0, 0, 0));
      tick(); ext_pin[k] = 1; tick(); pulse_cyc();
      chk("R7 rise taken", pack_out(), exp_out(1, k, 3, 0, 0));
      clear_all(); ext_pol[k] = 1;
      tick(); ext_pin[k] = 0; tick(); pulse_cyc();
      chk("R7 fall taken", pack_out(), exp_out(1, k, 3, 0, 0));
      clear_all();
      tick(); ext_pin[k] = 1; tick(); pulse_cyc();
      chk("R7 rise ignored when falling", pack_out(), exp_out(0, 0, 0, 0, 0));
      tick(); ext_pol[k] = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule